// File: doc/BRIEF.md
# Pixel Row Readout Sequencer

This block drives a pixel matrix one row step at a time. For each step it raises the gate line of the selected row, then asks the column readout for a first sample, which carries signal plus pedestal. It then pulses that row's clear line and asks for a second sample, which carries pedestal only. Last, it drops the gate and moves to the next row. The gate and clear lines leave the block as one-hot vectors, ready for external high-voltage switch drivers. Two strobes tell the column electronics when to take each sample. A row index output names the step being read.

A start pulse launches a frame over rows 0 to the programmed last row. In double-row mode two adjacent rows are gated and cleared together, so a frame takes half as many steps. In continuous mode the sequencer wraps to row 0 after each frame. A one-cycle frame-done pulse marks every frame boundary. A stop request ends the run cleanly at the end of the current row step. Every phase length is programmed in clock cycles. The configuration is captured only while the sequencer is idle, so a change in mid-frame cannot corrupt a readout.

Top module: `pixrow_seq_top`

## Requirements
- R1: During and after reset the sequencer is idle: all gate and clear bits, both sample strobes, busy and frame_done are 0, and row_idx is 0.
- R2: Each row step runs five phases in this fixed order, each lasting max(cfg,1) cycles. The phases are: settle (gate only, cfg_t_on), first sample (gate plus samp1, cfg_t_samp), clear (gate plus clear, cfg_t_clr), second sample (gate plus samp2, cfg_t_samp) and release (all low, cfg_t_off).
- R3: In single-row mode at most one gate bit is set at any time. In double-row mode at most two are set.
- R4: A clear bit is set only for a row whose gate is set, and only after that gate has been held for at least one earlier cycle.
- R5: In double-row mode a step at even row r gates and clears rows r and r+1, and row_idx advances by 2. Row r+1 is left out when it exceeds cfg_last_row.
- R6: row_idx is 12 bits wide and shows the lowest row of the current step, counting from 0 up to cfg_last_row.
- R7: frame_done is high for exactly one cycle, the cycle right after the release phase of the last step of a frame. In single-frame mode the sequencer is idle in that cycle.
- R8: In continuous mode the cycle after the last step's release begins the settle phase of row 0, with frame_done high.
- R9: A stop pulse while busy lets the current row step finish and then returns to idle. frame_done pulses only if that step was the last of its frame, and continuous mode does not wrap in that case.
- R10: Configuration inputs are captured only while idle. Changes to them while busy, and start pulses while busy, do not alter the running sequence.
- R11: samp1 and samp2 are never high together, and samp2 only rises directly after a clear phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Starts a frame when idle |
| stop | input | 1 | Ends the run after the current row step |
| cont_mode | input | 1 | 1: wrap to row 0 after each frame |
| dbl_mode | input | 1 | 1: activate row pairs |
| cfg_last_row | input | 12 | Index of the last row of a frame |
| cfg_t_on | input | 8 | Settle phase length in cycles |
| cfg_t_samp | input | 8 | Length of each sample phase in cycles |
| cfg_t_clr | input | 8 | Clear phase length in cycles |
| cfg_t_off | input | 8 | Release phase length in cycles |
| gate | output | 64 | One-hot row gate lines |
| clear | output | 64 | One-hot row clear lines |
| samp1 | output | 1 | First sample request |
| samp2 | output | 1 | Second sample request |
| row_idx | output | 12 | Lowest row of the current step |
| busy | output | 1 | Sequencer running |
| frame_done | output | 1 | One-cycle frame boundary pulse |

## Verification
Two events can meet in one cycle: a stop request and the end of the last row step of a frame in continuous mode. The bench provokes this by raising stop in the final release cycle of a frame. It then expects frame_done together with an idle sequencer instead of a wrap to row 0. Separate runs place stop in a middle row, where no frame_done may appear, and late in a second frame. A cycle-by-cycle model built from the phase lengths judges every gate, clear, strobe and index value.

// File: rtl/pixrow_pkg.sv
package pixrow_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SETTLE  = 3'd1,
    PH_SAMP1   = 3'd2,
    PH_CLEAR   = 3'd3,
    PH_SAMP2   = 3'd4,
    PH_RELEASE = 3'd5
  } phase_e;
endpackage

// File: rtl/pixrow_cfg_shadow.sv
module pixrow_cfg_shadow #(
  parameter int IDX_W = 12,
  parameter int PH_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             in_cont,
  input  logic             in_dbl,
  input  logic [IDX_W-1:0] in_last,
  input  logic [PH_W-1:0]  in_t_on,
  input  logic [PH_W-1:0]  in_t_samp,
  input  logic [PH_W-1:0]  in_t_clr,
  input  logic [PH_W-1:0]  in_t_off,
  output logic             q_cont,
  output logic             q_dbl,
  output logic [IDX_W-1:0] q_last,
  output logic [PH_W-1:0]  q_t_on,
  output logic [PH_W-1:0]  q_t_samp,
  output logic [PH_W-1:0]  q_t_clr,
  output logic [PH_W-1:0]  q_t_off
);
  // R10: capture only while the sequencer is idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_cont   <= 1'b0;
      q_dbl    <= 1'b0;
      q_last   <= '0;
      q_t_on   <= '0;
      q_t_samp <= '0;
      q_t_clr  <= '0;
      q_t_off  <= '0;
    end else if (load_en) begin
      q_cont   <= in_cont;
      q_dbl    <= in_dbl;
      q_last   <= in_last;
      q_t_on   <= in_t_on;
      q_t_samp <= in_t_samp;
      q_t_clr  <= in_t_clr;
      q_t_off  <= in_t_off;
    end
  end
endmodule

// File: rtl/pixrow_step_fsm.sv
module pixrow_step_fsm
  import pixrow_pkg::*;
#(
  parameter int IDX_W = 12,
  parameter int PH_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             cont,
  input  logic             dbl,
  input  logic [IDX_W-1:0] last_row,
  input  logic [PH_W-1:0]  t_on,
  input  logic [PH_W-1:0]  t_samp,
  input  logic [PH_W-1:0]  t_clr,
  input  logic [PH_W-1:0]  t_off,
  output phase_e           phase,
  output logic [IDX_W-1:0] row,
  output logic             frame_done,
  output logic             busy
);
  phase_e            phase_q, phase_d;
  logic [PH_W-1:0]   cnt_q, cnt_d;
  logic [IDX_W-1:0]  row_q, row_d;
  logic              fd_q, fd_d;
  logic              pend_q, pend_d;
  logic [PH_W-1:0]   len_sel, len_lim;
  logic              phase_end, stop_req, last_step, run_en;
  logic [IDX_W:0]    step_w, next_row_w;

  // phase length selection; a programmed 0 acts as 1 cycle
  always_comb begin
    unique case (phase_q)
      PH_SETTLE:           len_sel = t_on;
      PH_SAMP1, PH_SAMP2:  len_sel = t_samp;
      PH_CLEAR:            len_sel = t_clr;
      PH_RELEASE:          len_sel = t_off;
      default:             len_sel = '0;
    endcase
    len_lim = (len_sel == '0) ? '0 : len_sel - PH_W'(1);
  end

  assign phase_end  = (cnt_q == len_lim);
  assign stop_req   = stop | pend_q;
  assign step_w     = dbl ? (IDX_W+1)'(2) : (IDX_W+1)'(1);
  assign next_row_w = {1'b0, row_q} + step_w;
  assign last_step  = (next_row_w > {1'b0, last_row});
  assign run_en     = (phase_q != PH_IDLE) | start;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + PH_W'(1);
    row_d   = row_q;
    fd_d    = 1'b0;
    pend_d  = pend_q;
    if (phase_q == PH_IDLE) begin
      cnt_d  = '0;
      pend_d = 1'b0;
      if (start) begin
        phase_d = PH_SETTLE;
        row_d   = '0;
      end
    end else begin
      if (stop) pend_d = 1'b1;
      if (phase_end) begin
        cnt_d = '0;
        unique case (phase_q)
          PH_SETTLE: phase_d = PH_SAMP1;
          PH_SAMP1:  phase_d = PH_CLEAR;
          PH_CLEAR:  phase_d = PH_SAMP2;
          PH_SAMP2:  phase_d = PH_RELEASE;
          default: begin
            if (last_step) begin
              fd_d = 1'b1;
              if (cont && !stop_req) begin
                phase_d = PH_SETTLE;
                row_d   = '0;
              end else begin
                phase_d = PH_IDLE;
              end
            end else if (stop_req) begin
              phase_d = PH_IDLE;
            end else begin
              phase_d = PH_SETTLE;
              row_d   = next_row_w[IDX_W-1:0];
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      row_q   <= '0;
      fd_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      fd_q <= fd_d;
      if (run_en) begin
        phase_q <= phase_d;
        cnt_q   <= cnt_d;
        row_q   <= row_d;
        pend_q  <= pend_d;
      end
    end
  end

  assign phase      = phase_q;
  assign row        = row_q;
  assign frame_done = fd_q;
  assign busy       = (phase_q != PH_IDLE);

  // R2: first sample is entered only from the settle phase
  assert_sample_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SAMP1 && $past(phase_q) != PH_SAMP1) |-> ($past(phase_q) == PH_SETTLE));
  // R2: clear is entered only from the first sample
  assert_clear_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CLEAR && $past(phase_q) != PH_CLEAR) |-> ($past(phase_q) == PH_SAMP1));
  // R7: frame_done is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fd_q |=> !fd_q);
  // R5: paired steps always start on an even row
  assert_pair_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dbl) |-> !row_q[0]);
endmodule

// File: rtl/pixrow_line_drive.sv
module pixrow_line_drive
  import pixrow_pkg::*;
#(
  parameter int N_ROWS = 64,
  parameter int IDX_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [IDX_W-1:0]  row,
  input  logic              dbl,
  input  logic [IDX_W-1:0]  last_row,
  output logic [N_ROWS-1:0] gate,
  output logic [N_ROWS-1:0] clear,
  output logic              samp1,
  output logic              samp2
);
  logic           gate_on, clr_on;
  logic [IDX_W:0] row_w, partner_w;

  assign gate_on   = (phase == PH_SETTLE) | (phase == PH_SAMP1) |
                     (phase == PH_CLEAR)  | (phase == PH_SAMP2);
  assign clr_on    = (phase == PH_CLEAR);
  assign samp1     = (phase == PH_SAMP1);
  assign samp2     = (phase == PH_SAMP2);
  assign row_w     = {1'b0, row};
  assign partner_w = row_w + (IDX_W+1)'(1);

  for (genvar i = 0; i < N_ROWS; i++) begin : g_line
    localparam logic [IDX_W:0] IDX_I = (IDX_W+1)'(i);
    logic sel;
    assign sel      = (row_w == IDX_I) |
                      (dbl & (partner_w == IDX_I) & (IDX_I <= {1'b0, last_row}));
    assign gate[i]  = gate_on & sel;
    assign clear[i] = clr_on & sel;
  end

  // R3: one row, or one row pair, gated at a time
  assert_single_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl |-> $onehot0(gate));
  assert_pair_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gate) <= 2);
  // R4: clear only inside a gate that was already held
  assert_clear_in_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|clear) |-> ((gate == $past(gate)) && ((clear & ~gate) == '0)));
endmodule

// File: rtl/pixrow_seq_top.sv
module pixrow_seq_top
  import pixrow_pkg::*;
#(
  parameter int N_ROWS = 64,
  parameter int IDX_W  = 12,
  parameter int PH_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              cont_mode,
  input  logic              dbl_mode,
  input  logic [IDX_W-1:0]  cfg_last_row,
  input  logic [PH_W-1:0]   cfg_t_on,
  input  logic [PH_W-1:0]   cfg_t_samp,
  input  logic [PH_W-1:0]   cfg_t_clr,
  input  logic [PH_W-1:0]   cfg_t_off,
  output logic [N_ROWS-1:0] gate,
  output logic [N_ROWS-1:0] clear,
  output logic              samp1,
  output logic              samp2,
  output logic [IDX_W-1:0]  row_idx,
  output logic              busy,
  output logic              frame_done
);
  logic [1:0]       rs_q;
  logic             rst_int_n;
  logic             sh_cont, sh_dbl;
  logic [IDX_W-1:0] sh_last;
  logic [PH_W-1:0]  sh_on, sh_samp, sh_clr, sh_off;
  phase_e           phase;
  logic             busy_i;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  pixrow_cfg_shadow #(.IDX_W(IDX_W), .PH_W(PH_W)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .load_en(!busy_i),
    .in_cont(cont_mode), .in_dbl(dbl_mode), .in_last(cfg_last_row),
    .in_t_on(cfg_t_on), .in_t_samp(cfg_t_samp), .in_t_clr(cfg_t_clr), .in_t_off(cfg_t_off),
    .q_cont(sh_cont), .q_dbl(sh_dbl), .q_last(sh_last),
    .q_t_on(sh_on), .q_t_samp(sh_samp), .q_t_clr(sh_clr), .q_t_off(sh_off)
  );

  pixrow_step_fsm #(.IDX_W(IDX_W), .PH_W(PH_W)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .start(start), .stop(stop),
    .cont(sh_cont), .dbl(sh_dbl), .last_row(sh_last),
    .t_on(sh_on), .t_samp(sh_samp), .t_clr(sh_clr), .t_off(sh_off),
    .phase(phase), .row(row_idx), .frame_done(frame_done), .busy(busy_i)
  );

  pixrow_line_drive #(.N_ROWS(N_ROWS), .IDX_W(IDX_W)) u_drv (
    .clk(clk), .rst_n(rst_int_n), .phase(phase), .row(row_idx),
    .dbl(sh_dbl), .last_row(sh_last),
    .gate(gate), .clear(clear), .samp1(samp1), .samp2(samp2)
  );

  assign busy = busy_i;

  // R11: strobes exclusive; second sample follows a clear phase
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(samp1 && samp2));
  assert_samp2_after_clear_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(samp2) |-> $past(|clear));
endmodule

// File: tb/pixrow_seq_top_tb_top.sv
module pixrow_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 64;

  logic clk = 1'b0;
  logic rst_n, start, stop, cont_mode, dbl_mode;
  logic [11:0] cfg_last_row;
  logic [7:0]  cfg_t_on, cfg_t_samp, cfg_t_clr, cfg_t_off;
  logic [NR-1:0] gate, clear;
  logic samp1, samp2, busy, frame_done;
  logic [11:0] row_idx;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixrow_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .cont_mode(cont_mode), .dbl_mode(dbl_mode), .cfg_last_row(cfg_last_row),
    .cfg_t_on(cfg_t_on), .cfg_t_samp(cfg_t_samp), .cfg_t_clr(cfg_t_clr),
    .cfg_t_off(cfg_t_off), .gate(gate), .clear(clear), .samp1(samp1),
    .samp2(samp2), .row_idx(row_idx), .busy(busy), .frame_done(frame_done)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic [NR-1:0] act, logic [NR-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [NR-1:0] pair_mask(int r, bit d, int last);
    logic [NR-1:0] m = '0;
    m[r] = 1'b1;
    if (d && (r + 1 <= last)) m[r+1] = 1'b1;
    return m;
  endfunction

  // Drives one run and compares every cycle against the phase model.
  task automatic run_seq(string req, bit d, bit c, int last, int on, int smp,
                         int clr, int off, int stop_at, bit disturb);
    int cyc = 0;
    int r = 0;
    int step = d ? 2 : 1;
    bit stop_seen = 0;
    bit fd_exp = 0;
    bit end_fd = 0;
    bit done = 0;
    int lens[5];
    lens[0] = on; lens[1] = smp; lens[2] = clr; lens[3] = smp; lens[4] = off;
    dbl_mode = d; cont_mode = c; cfg_last_row = 12'(last);
    cfg_t_on = 8'(on); cfg_t_samp = 8'(smp); cfg_t_clr = 8'(clr); cfg_t_off = 8'(off);
    start = 1'b1;
    tick();
    start = 1'b0;
    while (!done) begin
      logic [NR-1:0] m = pair_mask(r, d, last);
      for (int ph = 0; ph < 5; ph++) begin
        int len = (lens[ph] == 0) ? 1 : lens[ph];
        for (int k = 0; k < len; k++) begin
          chk(req, "gate", gate, (ph < 4) ? m : '0);
          chk(req, "clear", clear, (ph == 2) ? m : '0);
          chk(req, "samp1", NR'(samp1), NR'(ph == 1));
          chk(req, "samp2", NR'(samp2), NR'(ph == 3));
          chk(req, "row_idx", NR'(row_idx), NR'(r));
          chk(req, "frame_done", NR'(frame_done), NR'(fd_exp));
          chk(req, "busy", NR'(busy), NR'(1));
          fd_exp = 0;
          if (cyc == stop_at) begin stop = 1'b1; stop_seen = 1; end
          else stop = 1'b0;
          if (disturb && cyc == 2) begin
            // R10: new settings and a start while busy must be ignored
            cfg_t_on = 8'd7; cfg_t_samp = 8'd5; cfg_t_clr = 8'd0; cfg_t_off = 8'd6;
            cfg_last_row = 12'd1; dbl_mode = ~d; cont_mode = 1'b1; start = 1'b1;
          end else begin
            start = 1'b0;
          end
          tick();
          cyc++;
        end
      end
      if (r + step > last) begin
        if (c && !stop_seen) begin r = 0; fd_exp = 1; end
        else begin done = 1; end_fd = 1; end
      end else if (stop_seen) begin
        done = 1;
      end else begin
        r = r + step;
      end
    end
    stop = 1'b0; start = 1'b0;
    chk(req, "idle busy", NR'(busy), NR'(0));
    chk(req, "idle gate", gate, '0);
    chk(req, "end frame_done", NR'(frame_done), NR'(end_fd));
    tick();
    chk(req, "frame_done drop", NR'(frame_done), NR'(0));
    chk(req, "still idle", NR'(busy), NR'(0));
  endtask

  task automatic test_reset();
    rst_n = 1'b0; start = 0; stop = 0; cont_mode = 0; dbl_mode = 0;
    cfg_last_row = '0; cfg_t_on = '0; cfg_t_samp = '0; cfg_t_clr = '0; cfg_t_off = '0;
    repeat (3) tick();
    chk("R1", "gate in reset", gate, '0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1", "gate", gate, '0);
    chk("R1", "clear", clear, '0);
    chk("R1", "strobes", NR'({samp1, samp2}), '0);
    chk("R1", "busy/done", NR'({busy, frame_done}), '0);
    chk("R1", "row_idx", NR'(row_idx), '0);
  endtask

  task automatic test_single_basic();   // R2 R3 R4 R6 R7 R11
    run_seq("R2", 0, 0, 3, 2, 3, 1, 2, -1, 0);
  endtask

  task automatic test_zero_lengths();   // R2: programmed 0 means 1 cycle
    run_seq("R2", 0, 0, 2, 0, 0, 0, 0, -1, 0);
  endtask

  task automatic test_long_index();     // R6: index runs past 8
    run_seq("R6", 0, 0, 11, 1, 1, 1, 1, -1, 0);
  endtask

  task automatic test_double_even();    // R5: paired rows, even count
    run_seq("R5", 1, 0, 5, 1, 2, 2, 1, -1, 0);
  endtask

  task automatic test_double_odd();     // R5: partner beyond last row masked
    run_seq("R5", 1, 0, 4, 1, 1, 2, 1, -1, 0);
  endtask

  task automatic test_ignore_busy();    // R10
    run_seq("R10", 0, 0, 2, 2, 2, 2, 2, -1, 1);
  endtask

  task automatic test_cont_wrap();      // R8: second frame after wrap, stop in its last row
    run_seq("R8", 0, 1, 3, 1, 1, 1, 1, 37, 0);
  endtask

  task automatic test_stop_mid();       // R9: stop in a middle row, no frame_done
    run_seq("R9", 0, 1, 3, 1, 1, 1, 1, 7, 0);
  endtask

  task automatic test_stop_at_wrap();   // R9/R7: stop in final cycle of the frame
    run_seq("R9", 0, 1, 3, 1, 1, 1, 1, 19, 0);
  endtask

  task automatic test_stop_double();    // R9 with pairs, R5
    run_seq("R9", 1, 1, 7, 1, 1, 1, 2, 13, 0);
  endtask

  initial begin
    test_reset();
    test_single_basic();
    test_zero_lengths();
    test_long_index();
    test_double_even();
    test_double_odd();
    test_ignore_busy();
    test_cont_wrap();
    test_stop_mid();
    test_stop_at_wrap();
    test_stop_double();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule